// File: doc/BRIEF.md
# Boot Remap Address Decoder

This block steers every address issued on the system side of the interconnect to one of four memory targets: static-memory chip select 0, static-memory chip select 1, the DDR controller, or the external AXI port. Four address windows change their target according to a 6-bit remap value. The upper four bits pick one of five layouts by priority. A separate swap bit exchanges the two NOR chip selects wherever a layout places NOR in the boot window. Addresses outside the four windows always go to a fixed target chosen by a parameter.

The two low remap bits restrict access by master. When bit 0 is set, the two core master ports are confined to the lower half of the map and to the top 16 MB. When bit 1 is set, the peripheral-port master is confined to the upper half. A restricted access raises the error output and selects no target. The decision is registered once, so both outputs follow the inputs with one clock of latency.

Top module: `remap_addr_decoder`

## Requirements
- R1: While rst_ni is low, sel_o is 4'b0000 and err_o is 0.
- R2: With remap_i[5:2]=4'b0000, the boot window 0x00000000–0x03FFFFFF selects NOR, 0x04000000–0x3FFFFFFF selects DDR, and both 0x60000000–0x7FFFFFFF and 0xC0000000–0xFFEFFFFF select external. NOR is chip select 0 (sel_o=4'b0001) when nor_swap_i=0 and chip select 1 (sel_o=4'b0010) when nor_swap_i=1. DDR is sel_o=4'b0100 and external is sel_o=4'b1000.
- R3: With remap_i[2]=1, whatever remap_i[5:3] and nor_swap_i hold, the boot and low windows select DDR and the mid and high windows select external.
- R4: With remap_i[3:2]=2'b10, the boot and low windows select external and the mid and high windows select DDR.
- R5: With remap_i[4:2]=3'b100, all four windows select DDR.
- R6: With remap_i[5:2]=4'b1000, the boot window selects NOR (the chip select follows nor_swap_i as in R2) and the other three windows select DDR.
- R7: In every mode, addresses outside the four windows select the target with index DFLT_TGT (default 3, external).
- R8: master_i encodes core 0 as 0, core 1 as 1, the peripheral port as 2 and any other master as 3. With remap_i[0]=1, a core master (0 or 1) addressing 0x80000000–0xFEFFFFFF gets err_o=1 and sel_o=4'b0000.
- R9: With remap_i[1]=1, master 2 addressing 0x00000000–0x7FFFFFFF gets err_o=1 and sel_o=4'b0000.
- R10: Master 3 is never restricted. With a remap bit cleared, its restriction does not apply, and the target follows R2–R7.
- R11: sel_o and err_o reflect the inputs sampled at the previous rising edge. Exactly one of {sel_o bits, err_o} is set after the first edge out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 32 | Access address |
| master_i | input | 2 | Master identifier (0 core0, 1 core1, 2 peripheral port, 3 other) |
| remap_i | input | 6 | Remap value: [5:2] layout, [1] peripheral limit, [0] core limit |
| nor_swap_i | input | 1 | Exchange NOR chip selects |
| sel_o | output | 4 | One-hot target: [0] NOR CS0, [1] NOR CS1, [2] DDR, [3] external |
| err_o | output | 1 | Access refused by master restriction |

## Verification
Directed cases place addresses on the first and last byte of each window and just past it. This separates the window edges from each other and from the pass-through region. Each layout is tried with extra set bits above its deciding bit, which tells the priority order apart from an exact-match decode. Each NOR layout is tried with both swap values. Random addresses are drawn near the region edges, under random masters and remap values, to mix restriction and layout effects. One case changes the inputs between edges to show the one-cycle latency.

// File: rtl/remap_dec_pkg.sv
package remap_dec_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned REMAP_W = 6;
  localparam int unsigned TGT_N   = 4;
  localparam int unsigned TGT_W   = $clog2(TGT_N);

  typedef enum logic [1:0] {TGT_NOR0, TGT_NOR1, TGT_DDR, TGT_EXT} tgt_e;
  typedef enum logic [2:0] {
    MODE_BOOT_NOR, MODE_DDR_LOW, MODE_EXT_LOW, MODE_ALL_DDR, MODE_NOR_DDR
  } mode_e;
  typedef enum logic [2:0] {WIN_BOOT, WIN_LOW, WIN_MID, WIN_HIGH, WIN_NONE} win_e;
  typedef enum logic [1:0] {MST_CORE0, MST_CORE1, MST_PERIPH, MST_OTHER} mst_e;

  localparam logic [ADDR_W-1:0] BOOT_END = 32'h03FF_FFFF;
  localparam logic [ADDR_W-1:0] LOW_END  = 32'h3FFF_FFFF;
  localparam logic [ADDR_W-1:0] MID_BEG  = 32'h6000_0000;
  localparam logic [ADDR_W-1:0] MID_END  = 32'h7FFF_FFFF;
  localparam logic [ADDR_W-1:0] HIGH_BEG = 32'hC000_0000;
  localparam logic [ADDR_W-1:0] HIGH_END = 32'hFFEF_FFFF;
  localparam logic [7:0]        TOP_MB   = 8'hFF;
endpackage

// File: rtl/remap_mode_dec.sv
module remap_mode_dec
  import remap_dec_pkg::*;
(
  input  logic [3:0] layout_i,
  output mode_e      mode_o
);
  // lowest set bit wins
  always_comb begin
    if (layout_i[0])      mode_o = MODE_DDR_LOW;
    else if (layout_i[1]) mode_o = MODE_EXT_LOW;
    else if (layout_i[2]) mode_o = MODE_ALL_DDR;
    else if (layout_i[3]) mode_o = MODE_NOR_DDR;
    else                  mode_o = MODE_BOOT_NOR;
  end
endmodule

// File: rtl/remap_win_class.sv
module remap_win_class
  import remap_dec_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output win_e              win_o
);
  always_comb begin
    if (addr_i <= BOOT_END)                            win_o = WIN_BOOT;
    else if (addr_i <= LOW_END)                        win_o = WIN_LOW;
    else if (addr_i >= MID_BEG && addr_i <= MID_END)   win_o = WIN_MID;
    else if (addr_i >= HIGH_BEG && addr_i <= HIGH_END) win_o = WIN_HIGH;
    else                                               win_o = WIN_NONE;
  end
endmodule

// File: rtl/remap_access_guard.sv
module remap_access_guard
  import remap_dec_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        master_i,
  input  logic [1:0]        limit_i,
  output logic              deny_o
);
  logic is_core, is_periph, core_bad, periph_bad;

  always_comb begin
    is_core    = (master_i == MST_CORE0) || (master_i == MST_CORE1);
    is_periph  = (master_i == MST_PERIPH);
    core_bad   = addr_i[ADDR_W-1] && (addr_i[ADDR_W-1 -: 8] != TOP_MB);
    periph_bad = !addr_i[ADDR_W-1];
    deny_o     = (limit_i[0] && is_core && core_bad) ||
                 (limit_i[1] && is_periph && periph_bad);
  end
endmodule

// File: rtl/remap_addr_decoder.sv
module remap_addr_decoder
  import remap_dec_pkg::*;
#(
  parameter int unsigned DFLT_TGT = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [1:0]          master_i,
  input  logic [REMAP_W-1:0]  remap_i,
  input  logic                nor_swap_i,
  output logic [TGT_N-1:0]    sel_o,
  output logic                err_o
);
  localparam logic [TGT_W-1:0] DFLT_IDX = TGT_W'(DFLT_TGT);

  mode_e            mode;
  win_e             win;
  logic             deny;
  tgt_e             nor_tgt;
  logic [TGT_W-1:0] tgt_idx;
  logic [TGT_N-1:0] sel_d;

  remap_mode_dec u_mode (
    .layout_i (remap_i[5:2]),
    .mode_o   (mode)
  );

  remap_win_class u_win (
    .addr_i (addr_i),
    .win_o  (win)
  );

  remap_access_guard u_guard (
    .addr_i   (addr_i),
    .master_i (master_i),
    .limit_i  (remap_i[1:0]),
    .deny_o   (deny)
  );

  assign nor_tgt = nor_swap_i ? TGT_NOR1 : TGT_NOR0;

  always_comb begin
    tgt_idx = DFLT_IDX;
    unique case (win)
      WIN_BOOT: unique case (mode)
        MODE_DDR_LOW, MODE_ALL_DDR: tgt_idx = TGT_DDR;
        MODE_EXT_LOW:               tgt_idx = TGT_EXT;
        default:                    tgt_idx = nor_tgt;
      endcase
      WIN_LOW: unique case (mode)
        MODE_EXT_LOW: tgt_idx = TGT_EXT;
        default:      tgt_idx = TGT_DDR;
      endcase
      WIN_MID, WIN_HIGH: unique case (mode)
        MODE_BOOT_NOR, MODE_DDR_LOW: tgt_idx = TGT_EXT;
        default:                     tgt_idx = TGT_DDR;
      endcase
      default: tgt_idx = DFLT_IDX;
    endcase
  end

  for (genvar g = 0; g < TGT_N; g++) begin : g_sel
    assign sel_d[g] = !deny && (tgt_idx == TGT_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o <= '0;
      err_o <= 1'b0;
    end else begin
      sel_o <= sel_d;
      err_o <= deny;
    end
  end
endmodule

// File: rtl/remap_addr_decoder_chk.sv
module remap_addr_decoder_chk
  import remap_dec_pkg::*;
#(
  parameter int unsigned DFLT_TGT = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [1:0]         master_i,
  input logic [REMAP_W-1:0] remap_i,
  input logic               nor_swap_i,
  input logic [TGT_N-1:0]   sel_o,
  input logic               err_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  // R11
  excl_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> ($countones({sel_o, err_o}) == 1));

  // R8
  core_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remap_i[0] && master_i[1] == 1'b0 && addr_i[31] && addr_i[31:24] != 8'hFF)
    |=> (err_o && sel_o == '0));

  // R9
  periph_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remap_i[1] && master_i == 2'd2 && !addr_i[31]) |=> (err_o && sel_o == '0));

  // R3
  ddr_low_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i == 2'd3 && remap_i[2] && addr_i < 32'h0400_0000) |=> (sel_o == 4'b0100));

  // R2
  boot_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i == 2'd3 && remap_i[5:2] == 4'b0000 && addr_i < 32'h0400_0000)
    |=> (sel_o == ($past(nor_swap_i) ? 4'b0010 : 4'b0001)));

  // R7
  pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i == 2'd3 && addr_i >= 32'h4000_0000 && addr_i < 32'h6000_0000)
    |=> (sel_o == (TGT_N'(1) << DFLT_TGT)));
endmodule

bind remap_addr_decoder remap_addr_decoder_chk #(.DFLT_TGT(DFLT_TGT)) u_chk (.*);

// File: tb/tb_remap_addr_decoder.sv
`timescale 1ns/1ps
module tb_remap_addr_decoder;
  localparam int DFLT = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] addr_i = '0;
  logic [1:0]  master_i = '0;
  logic [5:0]  remap_i = '0;
  logic        nor_swap_i = 1'b0;
  logic [3:0]  sel_o;
  logic        err_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  remap_addr_decoder #(.DFLT_TGT(DFLT)) dut (.*);

  function automatic logic [4:0] ref_out(logic [31:0] a, logic [1:0] m,
                                         logic [5:0] r, logic sw);
    logic [3:0] nor_sel, ddr, ext, s;
    int mode, win;
    nor_sel = sw ? 4'b0010 : 4'b0001;
    ddr = 4'b0100;
    ext = 4'b1000;
    if ((r[0] && m < 2 && a >= 32'h8000_0000 && a < 32'hFF00_0000) ||
        (r[1] && m == 2 && a < 32'h8000_0000))
      return 5'b10000;
    if (r[2]) mode = 1; else if (r[3]) mode = 2; else if (r[4]) mode = 3;
    else if (r[5]) mode = 4; else mode = 0;
    if (a < 32'h0400_0000) win = 0;
    else if (a < 32'h4000_0000) win = 1;
    else if (a >= 32'h6000_0000 && a < 32'h8000_0000) win = 2;
    else if (a >= 32'hC000_0000 && a < 32'hFFF0_0000) win = 3;
    else win = 4;
    case (win)
      0: s = (mode == 1 || mode == 3) ? ddr : (mode == 2) ? ext : nor_sel;
      1: s = (mode == 2) ? ext : ddr;
      2, 3: s = (mode <= 1) ? ext : ddr;
      default: s = 4'(1) << DFLT;
    endcase
    return {1'b0, s};
  endfunction

  function automatic string tag_of(logic [31:0] a, logic [1:0] m, logic [5:0] r);
    logic [4:0] e;
    e = ref_out(a, m, r, 1'b0);
    if (e[4]) return (m == 2) ? "R9" : "R8";
    if (m == 3 && r[1:0] != 0) return "R10";
    if (!(a < 32'h4000_0000 || (a >= 32'h6000_0000 && a < 32'h8000_0000) ||
          (a >= 32'hC000_0000 && a < 32'hFFF0_0000))) return "R7";
    if (r[2]) return "R3";
    if (r[3]) return "R4";
    if (r[4]) return "R5";
    if (r[5]) return "R6";
    return "R2";
  endfunction

  task automatic compare(string tag, logic [4:0] exp);
    checks++;
    if ({err_o, sel_o} !== exp) begin
      failures++;
      $display("FAIL %s: actual err=%b sel=%b expected err=%b sel=%b",
               tag, err_o, sel_o, exp[4], exp[3:0]);
    end
  endtask

  task automatic apply(logic [31:0] a, logic [1:0] m, logic [5:0] r,
                       logic sw, string tag);
    @(negedge clk_i);
    addr_i = a; master_i = m; remap_i = r; nor_swap_i = sw;
    @(negedge clk_i);
    compare(tag, ref_out(a, m, r, sw));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual hung expected done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset holds outputs low despite active inputs
    addr_i = 32'h0000_0100; master_i = 2'd3;
    repeat (3) @(negedge clk_i);
    compare("R1", 5'b00000);
    @(negedge clk_i); rst_ni = 1'b1;

    // R2
    apply(32'h0000_1000, 2'd3, 6'b000000, 1'b0, "R2");
    apply(32'h03FF_FFFF, 2'd3, 6'b000000, 1'b1, "R2");
    apply(32'h0400_0000, 2'd0, 6'b000000, 1'b0, "R2");
    apply(32'h6000_0000, 2'd1, 6'b000000, 1'b0, "R2");
    apply(32'hFFEF_FFFF, 2'd3, 6'b000000, 1'b1, "R2");
    // R3: bit 2 wins over higher bits and swap
    apply(32'h03FF_FFFF, 2'd3, 6'b111100, 1'b1, "R3");
    apply(32'h3FFF_FFFF, 2'd3, 6'b101100, 1'b0, "R3");
    apply(32'hC000_0000, 2'd3, 6'b111100, 1'b0, "R3");
    // R4
    apply(32'h0000_0000, 2'd3, 6'b111000, 1'b1, "R4");
    apply(32'h7FFF_FFFF, 2'd3, 6'b001000, 1'b0, "R4");
    // R5
    apply(32'h0000_0004, 2'd3, 6'b110000, 1'b1, "R5");
    apply(32'hC000_0000, 2'd3, 6'b010000, 1'b0, "R5");
    // R6
    apply(32'h0000_0000, 2'd3, 6'b100000, 1'b1, "R6");
    apply(32'h0100_0000, 2'd3, 6'b100000, 1'b0, "R6");
    apply(32'h6000_0000, 2'd3, 6'b100000, 1'b0, "R6");
    // R7: edges just outside windows
    apply(32'h4000_0000, 2'd3, 6'b010000, 1'b0, "R7");
    apply(32'h5FFF_FFFF, 2'd3, 6'b000100, 1'b0, "R7");
    apply(32'hBFFF_FFFF, 2'd3, 6'b100000, 1'b0, "R7");
    apply(32'hFFF0_0000, 2'd3, 6'b001000, 1'b0, "R7");
    // R8
    apply(32'h8000_0000, 2'd0, 6'b000001, 1'b0, "R8");
    apply(32'hFEFF_FFFF, 2'd1, 6'b000001, 1'b0, "R8");
    apply(32'hFF00_0000, 2'd0, 6'b000001, 1'b0, "R8");
    apply(32'h7FFF_FFFF, 2'd1, 6'b000001, 1'b0, "R8");
    // R9
    apply(32'h7FFF_FFFF, 2'd2, 6'b000010, 1'b0, "R9");
    apply(32'h8000_0000, 2'd2, 6'b000010, 1'b0, "R9");
    // R10
    apply(32'h0000_0000, 2'd3, 6'b000011, 1'b0, "R10");
    apply(32'h9000_0000, 2'd3, 6'b000011, 1'b0, "R10");
    apply(32'h9000_0000, 2'd0, 6'b000010, 1'b0, "R10");
    apply(32'h0000_0000, 2'd2, 6'b000001, 1'b1, "R10");

    // R11: output holds until the next rising edge
    apply(32'h0400_0000, 2'd3, 6'b000000, 1'b0, "R11");
    @(negedge clk_i);
    addr_i = 32'h6000_0000;
    #1 compare("R11", 5'b00100);
    @(negedge clk_i);
    compare("R11", 5'b01000);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      logic [31:0] bases [8];
      bases = '{32'h0, 32'h0400_0000, 32'h4000_0000, 32'h6000_0000,
                32'h8000_0000, 32'hC000_0000, 32'hFF00_0000, 32'hFFF0_0000};
      a = bases[$urandom_range(0, 7)] + $urandom_range(0, 3) - 32'd2;
      if ($urandom_range(0, 3) == 0) a = $urandom;
      begin
        logic [1:0] m;
        logic [5:0] r;
        m = 2'($urandom_range(0, 3));
        r = 6'($urandom_range(0, 63));
        apply(a, m, r, 1'($urandom_range(0, 1)), tag_of(a, m, r));
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule